// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Byte Codec

This block guards one byte of memory with five redundancy bits. On the write side it takes a data byte and produces four Hamming check bits and one overall parity bit, which the caller stores beside the byte as a 13-bit word. On the read side it takes a stored byte and its five stored redundancy bits. It recomputes the check bits and forms a syndrome. It then returns the byte, repaired if one data bit went bad, with a two-bit status code.

Each path has one registered output stage and so one clock cycle of latency. A registered output changes only in a cycle where its path's valid input is high, so the last result stays visible between requests. An active-low synchronous reset clears every output. The memory array, scrubbing and error logging are not part of this block.

Top module: `ecc_codec`

## Requirements
- R1: The check bits are numbered by codeword position, with positions 1 to 12. Check bits sit at positions 1, 2, 4 and 8. Data bits D1..D8 (wr_data[0]..wr_data[7]) sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. enc_chk[3:0] = {C8,C4,C2,C1}, where C1 = D1^D2^D4^D5^D7, C2 = D1^D3^D4^D6^D7, C4 = D2^D3^D4^D8 and C8 = D5^D6^D7^D8. For example, data 0x39 gives 4'b0111 and data 0x3D gives 4'b0001.
- R2: enc_chk[4] is the overall parity bit. It makes the count of ones in wr_data and enc_chk[3:0] together with itself even.
- R3: enc_valid equals wr_valid delayed by one clock. enc_chk is loaded only in a cycle where wr_valid is high, and holds its value otherwise.
- R4: The syndrome is rd_chk[3:0] XOR the check bits recomputed from rd_data, ordered {C8,C4,C2,C1}. If the syndrome is zero and the overall parity over rd_data and all of rd_chk is even, then dec_data = rd_data and dec_status = 2'b00 (clean).
- R5: If the syndrome has two or more bits set, names a data position from 3 to 12, and the overall parity is odd, then the data bit at that position is inverted. dec_status is then 2'b01 (data corrected).
- R6: If the syndrome has exactly one bit set and the overall parity is odd, one check bit is at fault. dec_data = rd_data and dec_status = 2'b10 (redundancy fault, data intact).
- R7: If the syndrome is zero and the overall parity is odd, the stored parity bit is at fault. dec_data = rd_data and dec_status = 2'b10.
- R8: If the syndrome is nonzero and the overall parity is even, a double error has occurred. dec_data = rd_data, uncorrected, and dec_status = 2'b11 (uncorrectable).
- R9: If the syndrome is 13, 14 or 15 and the overall parity is odd, dec_data = rd_data and dec_status = 2'b11.
- R10: dec_valid equals rd_valid delayed by one clock. dec_data and dec_status are loaded only in a cycle where rd_valid is high, and hold their values otherwise.
- R11: A clock edge with rst_n low sets enc_valid, enc_chk, dec_valid, dec_data and dec_status to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write byte is present |
| wr_data | input | 8 | Byte to encode, D1 in bit 0 |
| enc_valid | output | 1 | Encoded redundancy bits are valid |
| enc_chk | output | 5 | {parity, C8, C4, C2, C1} to store |
| rd_valid | input | 1 | A stored word is present |
| rd_data | input | 8 | Stored byte |
| rd_chk | input | 5 | Stored {parity, C8, C4, C2, C1} |
| dec_valid | output | 1 | Decode result is valid |
| dec_data | output | 8 | Byte after correction |
| dec_status | output | 2 | 00 clean, 01 corrected, 10 redundancy fault, 11 uncorrectable |

## Verification
Encoding is tried on several bytes, including both example bytes, all zeros and all ones. This separates the individual check equations and the parity bit. Decoding then gets clean words, every single data-bit flip and every single check-bit flip. These separate repair of the named data position from leaving a check-bit fault alone. A flip of only the parity bit shows that a zero syndrome with odd parity is not taken as clean. Every pair of the 13 stored bits is then flipped, and triple flips push the syndrome to 13 and 14. These show that the parity bit, not the syndrome, decides between a repair and a report of an uncorrectable word.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned RED_W  = CHK_W + 1;
  localparam int unsigned CW_LEN = DATA_W + CHK_W;
  localparam int unsigned ST_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_REDUN  = 2'b10,
    ST_UNCORR = 2'b11
  } ecc_status_e;

  // codeword position (1-based) of data bit idx: the idx-th position that is
  // not a power of two
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned n;
    data_pos = 0;
    n = 0;
    for (int unsigned p = 1; p <= CW_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) data_pos = p;
        n++;
      end
    end
  endfunction

  // check bit k covers every data bit whose position has bit k set
  function automatic logic [CHK_W-1:0] calc_check(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int unsigned k = 0; k < CHK_W; k++) begin
      for (int unsigned i = 0; i < DATA_W; i++) begin
        if (((data_pos(i) >> k) & 1) != 0) c[k] = c[k] ^ d[i];
      end
    end
    return c;
  endfunction

  function automatic logic calc_parity(logic [DATA_W-1:0] d, logic [CHK_W-1:0] c);
    return (^d) ^ (^c);
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [RED_W-1:0]  out_red
);

  logic [CHK_W-1:0] chk_w;
  logic             par_w;

  assign chk_w = calc_check(in_data);
  assign par_w = calc_parity(in_data, chk_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_red   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_red <= {par_w, chk_w};
    end
  end

  // R3
  enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R3
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_red) && !out_valid);

  // R2
  enc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ^{out_red, $past(in_data)} == 1'b0);

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] rd_data,
  input  logic [RED_W-1:0]  rd_red,
  output logic [CHK_W-1:0]  syn,
  output logic              par_odd
);

  logic [CHK_W-1:0] fresh_chk;

  assign fresh_chk = calc_check(rd_data);
  assign syn       = rd_red[CHK_W-1:0] ^ fresh_chk;
  assign par_odd   = (^rd_data) ^ (^rd_red);

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  syn,
  input  logic              par_odd,
  output logic [DATA_W-1:0] data_o,
  output ecc_status_e       status,
  output logic              syn_single,
  output logic              pos_hit
);

  logic [DATA_W-1:0] flip_mask;
  logic              syn_zero;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pos
    localparam int unsigned POS = data_pos(i);
    assign flip_mask[i] = (syn == CHK_W'(POS));
  end

  assign syn_zero   = (syn == '0);
  assign syn_single = !syn_zero && ((syn & (syn - 1'b1)) == '0);
  assign pos_hit    = |flip_mask;

  always_comb begin
    data_o = data_i;
    status = ST_CLEAN;
    if (syn_zero) begin
      status = par_odd ? ST_REDUN : ST_CLEAN;
    end else if (!par_odd) begin
      status = ST_UNCORR;
    end else if (syn_single) begin
      status = ST_REDUN;
    end else if (pos_hit) begin
      status = ST_FIXED;
      data_o = data_i ^ flip_mask;
    end else begin
      status = ST_UNCORR;
    end
  end

endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  enc_valid,
  output logic [RED_W-1:0]      enc_chk,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [RED_W-1:0]      rd_chk,
  output logic                  dec_valid,
  output logic [DATA_W-1:0]     dec_data,
  output logic [ST_W-1:0]       dec_status
);

  logic [CHK_W-1:0]  syn_w;
  logic              par_odd_w;
  logic [DATA_W-1:0] fixed_w;
  ecc_status_e       status_w;
  logic              syn_single_w;
  logic              pos_hit_w;

  ecc_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_data   (wr_data),
    .out_valid (enc_valid),
    .out_red   (enc_chk)
  );

  ecc_syndrome u_syn (
    .rd_data (rd_data),
    .rd_red  (rd_chk),
    .syn     (syn_w),
    .par_odd (par_odd_w)
  );

  ecc_corrector u_fix (
    .data_i     (rd_data),
    .syn        (syn_w),
    .par_odd    (par_odd_w),
    .data_o     (fixed_w),
    .status     (status_w),
    .syn_single (syn_single_w),
    .pos_hit    (pos_hit_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_data   <= '0;
      dec_status <= '0;
    end else begin
      dec_valid <= rd_valid;
      if (rd_valid) begin
        dec_data   <= fixed_w;
        dec_status <= status_w;
      end
    end
  end

  // R4
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && syn_w == '0 && !par_odd_w |=> dec_status == ST_CLEAN && dec_data == $past(rd_data));

  // R5
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && status_w == ST_FIXED |=> $countones(dec_data ^ $past(rd_data)) == 1);

  // R6
  chk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && syn_single_w && par_odd_w |=> dec_status == ST_REDUN && dec_data == $past(rd_data));

  // R8
  double_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && syn_w != '0 && !par_odd_w |=> dec_status == ST_UNCORR && dec_data == $past(rd_data));

  // R9
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && par_odd_w && !syn_single_w && syn_w != '0 && !pos_hit_w |=> dec_status == ST_UNCORR);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !dec_valid && $stable(dec_data) && $stable(dec_status));

endmodule

// File: tb/ecc_codec_bench.sv
module ecc_codec_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       enc_valid;
  logic [4:0] enc_chk;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic [4:0] rd_chk = '0;
  logic       dec_valid;
  logic [7:0] dec_data;
  logic [1:0] dec_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ecc_codec u_ecc_codec (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .enc_valid(enc_valid), .enc_chk(enc_chk),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_status(dec_status)
  );

  // redundancy word written straight from the R1/R2 equations
  function automatic logic [4:0] model_red(logic [7:0] d);
    logic c1, c2, c4, c8;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    return {(^d) ^ c1 ^ c2 ^ c4 ^ c8, c8, c4, c2, c1};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_read(logic [7:0] d, logic [4:0] c);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_chk = c;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R11 enc_valid", enc_valid, 0);
    chk("R11 enc_chk", enc_chk, 0);
    chk("R11 dec_valid", dec_valid, 0);
    chk("R11 dec_data", dec_data, 0);
    chk("R11 dec_status", dec_status, 0);
  endtask

  task automatic t_encode();
    logic [7:0] pats [6] = '{8'h39, 8'h3D, 8'h00, 8'hFF, 8'hA5, 8'h5A};
    foreach (pats[i]) begin
      do_write(pats[i]);
      chk("R3 enc_valid", enc_valid, 1);
      chk("R1 check bits", enc_chk[3:0], model_red(pats[i]) & 5'h0F);
      chk("R2 parity bit", enc_chk[4], model_red(pats[i]) >> 4);
      if (pats[i] == 8'h39) chk("R1 example 0x39", enc_chk[3:0], 4'b0111);
      if (pats[i] == 8'h3D) chk("R1 example 0x3D", enc_chk[3:0], 4'b0001);
    end
    @(negedge clk);
    wr_data = 8'hC3;
    @(negedge clk);
    chk("R3 enc_valid low", enc_valid, 0);
    chk("R3 enc_chk held", enc_chk, model_red(8'h5A));
  endtask

  task automatic t_clean();
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h39, 8'h96};
    foreach (pats[i]) begin
      do_read(pats[i], model_red(pats[i]));
      chk("R10 dec_valid", dec_valid, 1);
      chk("R4 status", dec_status, 2'b00);
      chk("R4 data", dec_data, pats[i]);
    end
  endtask

  task automatic t_data_flip();
    logic [7:0] pats [3] = '{8'h39, 8'hFF, 8'h6C};
    foreach (pats[p]) begin
      for (int b = 0; b < 8; b++) begin
        do_read(pats[p] ^ (8'h01 << b), model_red(pats[p]));
        chk("R5 status", dec_status, 2'b01);
        chk("R5 data", dec_data, pats[p]);
      end
    end
    // D3 of 0x39 goes bad: syndrome 0110 points at position 6
    do_read(8'h3D, model_red(8'h39));
    chk("R5 example D3", dec_data, 8'h39);
  endtask

  task automatic t_chk_flip();
    logic [7:0] pats [3] = '{8'h39, 8'h00, 8'hE1};
    foreach (pats[p]) begin
      for (int k = 0; k < 4; k++) begin
        do_read(pats[p], model_red(pats[p]) ^ (5'h01 << k));
        chk("R6 status", dec_status, 2'b10);
        chk("R6 data", dec_data, pats[p]);
      end
      do_read(pats[p], model_red(pats[p]) ^ 5'h10);
      chk("R7 status", dec_status, 2'b10);
      chk("R7 data", dec_data, pats[p]);
    end
  endtask

  task automatic t_double();
    logic [7:0] base;
    logic [12:0] word, bad;
    base = 8'h4B;
    word = {model_red(base), base};
    for (int a = 0; a < 13; a++) begin
      for (int b = a + 1; b < 13; b++) begin
        bad = word ^ (13'h1 << a) ^ (13'h1 << b);
        do_read(bad[7:0], bad[12:8]);
        chk("R8 status", dec_status, 2'b11);
        chk("R8 data", dec_data, bad[7:0]);
      end
    end
  endtask

  task automatic t_range();
    logic [7:0] base;
    base = 8'h27;
    // flip C8,C4,C1: syndrome 13, odd parity
    do_read(base, model_red(base) ^ 5'b01101);
    chk("R9 syndrome 13 status", dec_status, 2'b11);
    chk("R9 syndrome 13 data", dec_data, base);
    // flip C8,C4,C2: syndrome 14
    do_read(base, model_red(base) ^ 5'b01110);
    chk("R9 syndrome 14 status", dec_status, 2'b11);
    chk("R9 syndrome 14 data", dec_data, base);
  endtask

  task automatic t_hold();
    do_read(8'h81, model_red(8'h81) ^ 5'h10);
    @(negedge clk);
    rd_data = 8'h55; rd_chk = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    chk("R10 valid low", dec_valid, 0);
    chk("R10 data held", dec_data, 8'h81);
    chk("R10 status held", dec_status, 2'b10);
  endtask

  task automatic t_mid_reset();
    do_write(8'hF0);
    do_read(8'h33, model_red(8'h33) ^ 5'b00110);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_encode();
    t_clean();
    t_data_flip();
    t_chk_flip();
    t_double();
    t_range();
    t_hold();
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule